// File: doc/BRIEF.md
# Dual-Mode Host Bus Front End

This block sits between a microcontroller and a display controller core. It accepts host accesses in one of three forms: an 8-bit parallel bus with active-low read and write strobes, an 8-bit parallel bus with an active-high enable and a read/not-write line, or a write-only serial stream that uses two of the data pins. Every completed access becomes one single-cycle strobe toward the core, and write strobes come with an 8-bit payload. The four transaction kinds are display-data write, display-data read, status read and command write.

All pins are brought into the fast system clock domain through two-flop synchronizers, and edges are found there. The block decides the data bus direction. It drives the bus only during a selected parallel read whose strobe is active. During such a read it returns the core's read data when the address line is high, and the busy flag on bit 7 when the address line is low.

Top module: `hostbus_front`

## Requirements
- R1: The block is selected only while `cs_n_i` is 0 and `cs_i` is 1. While it is deselected, no strobe is issued, the output enable stays 0, and the address, read and write pins have no effect.
- R2: Low-strobe parallel mode (`par_sel_i`=1, `mode68_i`=0). A 1-to-0-to-1 pulse on `wr_i` issues one strobe after the rising edge. It is `dwr_stb_o` when `a0_i` was 1 during the pulse and `cmd_stb_o` when `a0_i` was 0. `payload_o` carries the bus value present while `wr_i` was low.
- R3: In low-strobe parallel mode, a falling edge on `rd_i` issues `drd_stb_o` when `a0_i` is 1 and `srd_stb_o` when `a0_i` is 0.
- R4: Enable parallel mode (`mode68_i`=1). `rd_i` acts as an active-high enable and `wr_i` as read/not-write, where 1 means read. A read strobe is issued at the rising edge of the enable when `wr_i` is 1. A write strobe, carrying the bus value captured while the enable was high, is issued at the falling edge of the enable when `wr_i` is 0. The strobe kind follows `a0_i` as in R2 and R3.
- R5: `dbus_oe_o` is all ones while a selected parallel read has its strobe active, and all zeros otherwise.
- R6: Serial mode (`par_sel_i`=0). Bit 7 of `dbus_i` is serial data and bit 6 is the serial clock. Bits are shifted in MSB first on rising clock edges. On the 8th rising edge, `a0_i` is sampled: the assembled byte is issued with `dwr_stb_o` if it is 1 and with `cmd_stb_o` if it is 0.
- R7: In serial mode, no read strobe is issued and `dbus_oe_o` stays 0, whatever `rd_i` and `wr_i` do.
- R8: In serial mode, deselecting the block discards any partial byte. After reselection, the next 8 clock edges form a new byte.
- R9: During a status read, `dbus_o` is `{busy_i, 7'b0}`. During a display-data read, it is `rdata_i`.
- R10: Each completed access produces exactly one strobe that lasts one cycle. At most one of the four strobes is high in any cycle.
- R11: After reset, all strobes and `dbus_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Active-low chip select |
| cs_i | input | 1 | Active-high chip select |
| a0_i | input | 1 | Data (1) / control (0) selector |
| rd_i | input | 1 | Read strobe (low-strobe mode) or enable (enable mode) |
| wr_i | input | 1 | Write strobe (low-strobe mode) or read/not-write (enable mode) |
| mode68_i | input | 1 | 1: enable-style bus, 0: low-strobe bus |
| par_sel_i | input | 1 | 1: parallel bus, 0: serial stream |
| dbus_i | input | 8 | Data bus pad input |
| busy_i | input | 1 | Busy flag from the core |
| rdata_i | input | 8 | Display read data from the core |
| dbus_o | output | 8 | Data bus pad output value |
| dbus_oe_o | output | 8 | Data bus pad output enable per bit |
| dwr_stb_o | output | 1 | Display-data write strobe |
| drd_stb_o | output | 1 | Display-data read strobe |
| srd_stb_o | output | 1 | Status read strobe |
| cmd_stb_o | output | 1 | Command write strobe |
| payload_o | output | 8 | Write payload, valid with a write strobe |

## Verification
A bit counter that is off by one in serial mode does not fail at once. Every byte after the error comes out shifted, and the core sees the wrong payload on the very next byte. A counter that is not cleared on deselect shows up as a misaligned byte on the first transfer after reselection. An edge detector with stale previous state shows up as a strobe that is missing or doubled, three system cycles after the pin edge. A wrong latched address bit shows up as the wrong strobe kind, or as status data driven where display data was expected. The scoreboard checks kind and payload for every strobe, so each of these faults appears at the first access that passes through the bad state.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
    parameter int unsigned HBF_DW = 8;

    typedef enum logic [2:0] {
        TX_NONE = 3'd0,
        TX_DWR  = 3'd1,
        TX_DRD  = 3'd2,
        TX_SRD  = 3'd3,
        TX_CMD  = 3'd4
    } txn_e;

    typedef struct packed {
        logic              valid;
        txn_e              kind;
        logic [HBF_DW-1:0] payload;
    } evt_t;
endpackage

// File: rtl/hbf_sync.sv
module hbf_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.meta   <= RST_VAL;
            st_q.stable <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stable;
endmodule

// File: rtl/hbf_par.sv
module hbf_par
    import hbf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              mode68,
    input  logic              a0,
    input  logic              rd_pin,
    input  logic              wr_pin,
    input  logic [HBF_DW-1:0] din,
    output evt_t              evt,
    output logic              rd_active
);
    typedef struct packed {
        logic              rd_prev;
        logic              wr_prev;
        logic              wa0;
        logic [HBF_DW-1:0] wdata;
    } par_t;

    par_t st_d, st_q;
    logic rd_act, wr_act;

    always_comb begin
        // enable style: rd_pin = enable, wr_pin = read/not-write
        rd_act = mode68 ? (rd_pin & wr_pin)  : ~rd_pin;
        wr_act = mode68 ? (rd_pin & ~wr_pin) : ~wr_pin;

        st_d         = st_q;
        st_d.rd_prev = rd_act;
        st_d.wr_prev = wr_act;
        if (wr_act) begin
            st_d.wdata = din;
            st_d.wa0   = a0;
        end

        evt = '0;
        if (en) begin
            if (rd_act && !st_q.rd_prev) begin
                evt.valid = 1'b1;
                evt.kind  = a0 ? TX_DRD : TX_SRD;
            end else if (!wr_act && st_q.wr_prev) begin
                evt.valid   = 1'b1;
                evt.kind    = st_q.wa0 ? TX_DWR : TX_CMD;
                evt.payload = st_q.wdata;
            end
        end
        rd_active = en & rd_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hbf_ser.sv
module hbf_ser
    import hbf_pkg::*;
#(
    parameter int unsigned CNT_W = $clog2(HBF_DW)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic a0,
    input  logic sclk,
    input  logic sdata,
    output evt_t evt
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(HBF_DW - 1);

    typedef struct packed {
        logic              sclk_prev;
        logic [CNT_W-1:0]  cnt;
        logic [HBF_DW-1:0] shreg;
    } ser_t;

    ser_t st_d, st_q;
    logic [HBF_DW-1:0] nxt;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk;
        evt            = '0;
        nxt            = {st_q.shreg[HBF_DW-2:0], sdata};

        if (!en) begin
            st_d.cnt   = '0;
            st_d.shreg = '0;
        end else if (sclk && !st_q.sclk_prev) begin
            if (st_q.cnt == LAST_BIT) begin
                evt.valid   = 1'b1;
                evt.kind    = a0 ? TX_DWR : TX_CMD;
                evt.payload = nxt;
                st_d.cnt    = '0;
                st_d.shreg  = '0;
            end else begin
                st_d.cnt   = st_q.cnt + 1'b1;
                st_d.shreg = nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hostbus_front.sv
module hostbus_front
    import hbf_pkg::*;
#(
    parameter int unsigned SCLK_BIT = 6,
    parameter int unsigned SDAT_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              cs_i,
    input  logic              a0_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic              mode68_i,
    input  logic              par_sel_i,
    input  logic [HBF_DW-1:0] dbus_i,
    input  logic              busy_i,
    input  logic [HBF_DW-1:0] rdata_i,
    output logic [HBF_DW-1:0] dbus_o,
    output logic [HBF_DW-1:0] dbus_oe_o,
    output logic              dwr_stb_o,
    output logic              drd_stb_o,
    output logic              srd_stb_o,
    output logic              cmd_stb_o,
    output logic [HBF_DW-1:0] payload_o
);
    localparam int unsigned CTRL_W = 7;
    // order: cs_n, cs, a0, rd, wr, mode68, par_sel
    localparam logic [CTRL_W-1:0] CTRL_IDLE = 7'b1001101;

    logic [CTRL_W-1:0] ctrl_s;
    logic [HBF_DW-1:0] dbus_s;
    logic cs_n_s, cs_s, a0_s, rd_s, wr_s, m68_s, par_s, sel;
    evt_t par_evt, ser_evt, evt;
    logic par_rd_act;

    hbf_sync #(.W(CTRL_W), .RST_VAL(CTRL_IDLE)) u_sync_ctrl (
        .clk(clk), .rst_n(rst_n),
        .async_i({cs_n_i, cs_i, a0_i, rd_i, wr_i, mode68_i, par_sel_i}),
        .sync_o(ctrl_s)
    );

    hbf_sync #(.W(HBF_DW), .RST_VAL('0)) u_sync_data (
        .clk(clk), .rst_n(rst_n), .async_i(dbus_i), .sync_o(dbus_s)
    );

    assign {cs_n_s, cs_s, a0_s, rd_s, wr_s, m68_s, par_s} = ctrl_s;
    assign sel = ~cs_n_s & cs_s;

    hbf_par u_par (
        .clk(clk), .rst_n(rst_n), .en(sel & par_s), .mode68(m68_s),
        .a0(a0_s), .rd_pin(rd_s), .wr_pin(wr_s), .din(dbus_s),
        .evt(par_evt), .rd_active(par_rd_act)
    );

    hbf_ser u_ser (
        .clk(clk), .rst_n(rst_n), .en(sel & ~par_s), .a0(a0_s),
        .sclk(dbus_s[SCLK_BIT]), .sdata(dbus_s[SDAT_BIT]), .evt(ser_evt)
    );

    typedef struct packed {
        logic              dwr;
        logic              drd;
        logic              srd;
        logic              cmd;
        logic              oe;
        logic              ra0;
        logic [HBF_DW-1:0] payload;
    } top_t;

    top_t st_d, st_q;

    always_comb begin
        evt          = par_s ? par_evt : ser_evt;
        st_d         = st_q;
        st_d.dwr     = evt.valid && (evt.kind == TX_DWR);
        st_d.drd     = evt.valid && (evt.kind == TX_DRD);
        st_d.srd     = evt.valid && (evt.kind == TX_SRD);
        st_d.cmd     = evt.valid && (evt.kind == TX_CMD);
        if (evt.valid && (evt.kind == TX_DWR || evt.kind == TX_CMD))
            st_d.payload = evt.payload;
        st_d.oe      = par_s & par_rd_act;
        st_d.ra0     = a0_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dwr_stb_o = st_q.dwr;
    assign drd_stb_o = st_q.drd;
    assign srd_stb_o = st_q.srd;
    assign cmd_stb_o = st_q.cmd;
    assign payload_o = st_q.payload;
    assign dbus_oe_o = {HBF_DW{st_q.oe}};
    assign dbus_o    = st_q.ra0 ? rdata_i : {busy_i, {(HBF_DW-1){1'b0}}};
endmodule

// File: rtl/hbf_chk.sv
module hbf_chk
    import hbf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_i,
    input logic              cs_i,
    input logic              par_sel_i,
    input logic [HBF_DW-1:0] dbus_oe_o,
    input logic              dwr_stb_o,
    input logic              drd_stb_o,
    input logic              srd_stb_o,
    input logic              cmd_stb_o
);
    logic any_stb;
    assign any_stb = dwr_stb_o | drd_stb_o | srd_stb_o | cmd_stb_o;

    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dwr_stb_o, drd_stb_o, srd_stb_o, cmd_stb_o}));

    a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |=> !any_stb);

    a_r1_strobe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |-> $past(!cs_n_i && cs_i, 3));

    a_r7_no_drive_serial: assert property (@(posedge clk) disable iff (!rst_n)
        (dbus_oe_o != '0) |-> $past(par_sel_i, 3));

    a_r5_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (drd_stb_o || srd_stb_o) |-> (dbus_oe_o == '1));

    a_r5_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (dwr_stb_o || cmd_stb_o) |-> (dbus_oe_o == '0));
endmodule

bind hostbus_front hbf_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .cs_i(cs_i),
    .par_sel_i(par_sel_i), .dbus_oe_o(dbus_oe_o),
    .dwr_stb_o(dwr_stb_o), .drd_stb_o(drd_stb_o),
    .srd_stb_o(srd_stb_o), .cmd_stb_o(cmd_stb_o)
);

// File: tb/sim_hostbus_front.sv
`timescale 1ns/1ps
module sim_hostbus_front;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, cs = 1'b0, a0 = 1'b0, rd = 1'b1, wr = 1'b1;
    logic m68 = 1'b0, par = 1'b1, busy = 1'b0;
    logic [7:0] dbus = 8'h00, rdata = 8'h00;
    logic [7:0] dout, doe, payload;
    logic dwr, drd, srd, cmd;

    int checks = 0, fails = 0;

    // kind codes: 0 dwr, 1 drd, 2 srd, 3 cmd
    typedef struct {
        int         kind;
        logic [7:0] data;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    hostbus_front u0 (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .cs_i(cs), .a0_i(a0),
        .rd_i(rd), .wr_i(wr), .mode68_i(m68), .par_sel_i(par),
        .dbus_i(dbus), .busy_i(busy), .rdata_i(rdata),
        .dbus_o(dout), .dbus_oe_o(doe), .dwr_stb_o(dwr), .drd_stb_o(drd),
        .srd_stb_o(srd), .cmd_stb_o(cmd), .payload_o(payload)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input int k, input logic [7:0] d, input string req);
        exp_t e;
        e.kind = k; e.data = d; e.req = req;
        sb.push_back(e);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    // monitor: pops and compares each strobe
    always @(negedge clk) begin
        if (rst_n && (dwr | drd | srd | cmd)) begin
            int k;
            k = dwr ? 0 : drd ? 1 : srd ? 2 : 3;
            chk(($countones({dwr, drd, srd, cmd}) == 1), "R10 single strobe",
                {dwr, drd, srd, cmd}, 0);
            if (sb.size() == 0) begin
                chk(0, "R1/R7/R10 unexpected strobe", k, 32'hFFFF);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(k == e.kind, {e.req, " kind"}, k, e.kind);
                if (k == 0 || k == 3)
                    chk(payload == e.data, {e.req, " payload"}, payload, e.data);
            end
        end
    end

    task automatic drain(input string req);
        cyc(10);
        chk(sb.size() == 0, {req, " all expected strobes seen"}, sb.size(), 0);
    endtask

    task automatic setmode(input logic p, input logic m);
        cs_n = 1'b1; cs = 1'b0;
        par = p; m68 = m;
        rd = m ? 1'b0 : 1'b1;   // idle: enable low / read strobe high
        wr = 1'b1;
        cyc(6);
        cs_n = 1'b0; cs = 1'b1;
        cyc(6);
    endtask

    task automatic wr80(input logic a, input logic [7:0] d, input bit expect_it, input string req);
        if (expect_it) push(a ? 0 : 3, d, req);
        a0 = a; dbus = d; cyc(1);
        wr = 1'b0; cyc(4);
        wr = 1'b1; cyc(4);
        dbus = ~d; cyc(2);
    endtask

    task automatic rd80(input logic a, input logic [7:0] exp_d, input bit expect_it, input string req);
        if (expect_it) push(a ? 1 : 2, 8'h00, req);
        a0 = a; cyc(1);
        rd = 1'b0; cyc(5);
        @(negedge clk);
        if (expect_it) begin
            chk(doe == 8'hFF, {req, " oe during read"}, doe, 8'hFF);
            chk(dout == exp_d, {req, " read data"}, dout, exp_d);
        end else begin
            chk(doe == 8'h00, {req, " no drive"}, doe, 8'h00);
        end
        rd = 1'b1; cyc(5);
        @(negedge clk);
        chk(doe == 8'h00, "R5 oe released after read", doe, 8'h00);
    endtask

    task automatic acc68(input logic rnw, input logic a, input logic [7:0] d, input string req);
        push(rnw ? (a ? 1 : 2) : (a ? 0 : 3), d, req);
        a0 = a; wr = rnw; dbus = d; cyc(2);
        rd = 1'b1; cyc(5);
        @(negedge clk);
        chk(doe == (rnw ? 8'hFF : 8'h00), {req, " oe in enable mode"}, doe, rnw ? 8'hFF : 8'h00);
        rd = 1'b0; cyc(4);
        wr = 1'b1; dbus = ~d; cyc(2);
    endtask

    task automatic sbits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            dbus[7] = b[i]; dbus[6] = 1'b0; cyc(3);
            dbus[6] = 1'b1; cyc(3);
        end
        dbus[6] = 1'b0; cyc(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        cyc(4);
        @(negedge clk) rst_n = 1'b1;
        cyc(2);
        @(negedge clk);
        chk({dwr, drd, srd, cmd} == 4'b0, "R11 strobes idle after reset", {dwr, drd, srd, cmd}, 0);
        chk(doe == 8'h00, "R11 oe idle after reset", doe, 0);

        // low-strobe parallel
        setmode(1'b1, 1'b0);
        wr80(1'b1, 8'hA5, 1, "R2 data write");
        wr80(1'b0, 8'h3C, 1, "R2 command write");
        wr80(1'b1, 8'h00, 1, "R2 data write zero");
        rdata = 8'h5A;
        rd80(1'b1, 8'h5A, 1, "R3 R9 data read");
        busy = 1'b1;
        rd80(1'b0, 8'h80, 1, "R3 R9 status busy");
        busy = 1'b0;
        rd80(1'b0, 8'h00, 1, "R9 status idle");
        drain("R2 R3");

        // deselected: ignored
        cs_n = 1'b1; cyc(4);
        wr80(1'b1, 8'h11, 0, "R1");
        rd80(1'b1, 8'h00, 0, "R1 read while deselected");
        cs_n = 1'b0; cs = 1'b0; cyc(4);
        wr80(1'b0, 8'h22, 0, "R1");
        drain("R1 deselected accesses ignored");
        cs = 1'b1; cyc(4);

        // enable-style parallel
        setmode(1'b1, 1'b1);
        acc68(1'b0, 1'b1, 8'hC3, "R4 data write");
        acc68(1'b0, 1'b0, 8'h7E, "R4 command write");
        acc68(1'b1, 1'b1, 8'h00, "R4 data read");
        acc68(1'b1, 1'b0, 8'h00, "R4 status read");
        drain("R4");

        // serial
        setmode(1'b0, 1'b0);
        dbus = 8'h00;
        a0 = 1'b1; push(0, 8'hB6, "R6 serial data byte"); sbits(8'hB6, 8);
        a0 = 1'b0; push(3, 8'h49, "R6 serial command byte"); sbits(8'h49, 8);
        a0 = 1'b1; push(0, 8'hFF, "R6 serial all ones"); sbits(8'hFF, 8);
        drain("R6");

        // serial partial byte discarded on deselect
        sbits(8'hE0, 3);
        cs_n = 1'b1; cyc(6);
        cs_n = 1'b0; cyc(6);
        a0 = 1'b0; push(3, 8'h96, "R8 realigned byte"); sbits(8'h96, 8);
        drain("R8");

        // serial: read strobes ignored
        rd80(1'b1, 8'h00, 0, "R7 serial read");
        wr80(1'b1, 8'h55, 0, "R7");
        drain("R7 no strobe from parallel pins in serial mode");

        cyc(5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule